// File: doc/BRIEF.md
# Majority-Clocked Three-Register Keystream Generator

This block turns a 64-bit secret key and a 22-bit frame counter into a burst of keystream bits, one bit per clock. It holds three linear feedback shift registers of 19, 22 and 23 bits. While the key and frame are loaded, every register steps on every cycle. After loading, each register steps only when its own clock-control bit agrees with the majority of the three clock-control bits.

A single start pulse begins a burst. The key and frame are absorbed serially over 86 cycles. Then 100 majority-clocked mixing cycles run with no output. Then 228 keystream bits come out with a valid strobe, and a done flag rises. The consumer XORs the bits with its own data. No further start is accepted until the burst has finished.

Top module: `kstream_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, ks_valid_o, ks_o and done_o are all 0.
- R2: The registers are A (19 bits, feedback XOR of bits 13, 16, 17, 18), B (22 bits, feedback XOR of bits 20, 21) and C (23 bits, feedback XOR of bits 7, 20, 21, 22). A step moves every bit one place toward the MSB, and the feedback enters at bit 0.
- R3: A start accepted while idle clears all three registers. The next 86 cycles load key bits 0..63 and then frame bits 0..21, one per cycle. Each bit is XORed into the bit 0 of every register, and all three registers step on each of these cycles.
- R4: The 100 cycles after loading are majority-clocked, and ks_valid_o stays 0 during them.
- R5: The clock-control bits are A[8], B[10] and C[10]. The majority is 1 when two or more of them are 1. Outside loading, a register steps exactly when its control bit equals the majority, and a register that does not step holds its value. At least two registers therefore step on each such cycle.
- R6: ks_valid_o is 1 on 228 consecutive cycles. The first of them is observed 187 clock edges after the edge that accepted start. On each of these cycles ks_o is the XOR of the three MSBs after that cycle's majority step.
- R7: done_o rises on the cycle right after the last valid bit and is never high together with ks_valid_o. It stays high until the next accepted start, which clears it on the accepting edge.
- R8: A start pulse that arrives while a burst is in progress has no effect. The burst keeps its timing and its bit values.
- R9: key_i and frame_i are sampled only on the edge that accepts start. Later changes do not alter the burst.
- R10: An all-zero key with an all-zero frame gives 228 keystream bits that are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst (accepted only when idle) |
| key_i | input | 64 | Secret key, bit 0 loaded first |
| frame_i | input | 22 | Frame number, loaded after the key, bit 0 first |
| ks_o | output | 1 | Keystream bit |
| ks_valid_o | output | 1 | ks_o carries a keystream bit |
| done_o | output | 1 | Burst finished; held until the next start |

## Verification
A wrong bit in any register during loading or mixing feeds back through the majority vote. It then changes the stepping pattern of all three registers, so it shows at ks_o within the first few valid bits of that burst. The bench therefore compares each whole 228-bit burst against an independent model. A fault in phase length or sequencing shows at once as a shifted first-valid cycle, a wrong count of valid bits, or a misplaced done_o. The bench measures each of these against the cycle of the accepting edge.

// File: rtl/kstream_pkg.sv
package kstream_pkg;

  localparam int R1_LEN = 19;
  localparam int R2_LEN = 22;
  localparam int R3_LEN = 23;

  localparam logic [R1_LEN-1:0] R1_TAPS = 19'h72000;   // 13,16,17,18
  localparam logic [R2_LEN-1:0] R2_TAPS = 22'h300000;  // 20,21
  localparam logic [R3_LEN-1:0] R3_TAPS = 23'h700080;  // 7,20,21,22

  localparam int R1_CTL = 8;
  localparam int R2_CTL = 10;
  localparam int R3_CTL = 10;

  localparam int N_REGS = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_MIX,
    PH_RUN,
    PH_FIN
  } phase_e;

endpackage

// File: rtl/kstream_lfsr.sv
module kstream_lfsr #(
  parameter int             LEN     = 19,
  parameter logic [LEN-1:0] TAPS    = '0,
  parameter int             CTL_BIT = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           step_i,
  input  logic           in_bit_i,
  output logic [LEN-1:0] state_o,
  output logic           ctl_o,
  output logic           msb_nxt_o
);

  logic [LEN-1:0] state_q;
  logic           fb;

  assign fb = (^(state_q & TAPS)) ^ in_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
    end else if (clear_i) begin
      state_q <= '0;
    end else if (step_i) begin
      state_q <= {state_q[LEN-2:0], fb};
    end
  end

  assign state_o   = state_q;
  assign ctl_o     = state_q[CTL_BIT];
  assign msb_nxt_o = step_i ? state_q[LEN-2] : state_q[LEN-1];

endmodule

// File: rtl/kstream_clk_ctl.sv
module kstream_clk_ctl
  import kstream_pkg::*;
#(
  parameter int N = N_REGS
) (
  input  logic         load_i,
  input  logic         vote_i,
  input  logic [N-1:0] ctl_i,
  output logic [N-1:0] step_o
);

  localparam int HALF = N / 2 + 1;

  logic maj;
  assign maj = ($countones(ctl_i) >= HALF);

  for (genvar i = 0; i < N; i++) begin : g_lane
    always_comb begin
      if (load_i)      step_o[i] = 1'b1;
      else if (vote_i) step_o[i] = (ctl_i[i] == maj);
      else             step_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/kstream_seq.sv
module kstream_seq
  import kstream_pkg::*;
#(
  parameter int KEY_W   = 64,
  parameter int FRAME_W = 22,
  parameter int MIX_LEN = 100,
  parameter int RUN_LEN = 228
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [FRAME_W-1:0] frame_i,
  output phase_e             phase_o,
  output logic               clear_o,
  output logic               load_bit_o,
  output logic               done_o
);

  localparam int LOAD_LEN = KEY_W + FRAME_W;
  localparam int MAX_A    = (LOAD_LEN > MIX_LEN) ? LOAD_LEN : MIX_LEN;
  localparam int MAX_LEN  = (MAX_A > RUN_LEN) ? MAX_A : RUN_LEN;
  localparam int CNT_W    = $clog2(MAX_LEN);

  phase_e              phase_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [LOAD_LEN-1:0] sh_q;
  logic                done_q;
  logic [CNT_W-1:0]    lim;
  logic                at_lim;

  always_comb begin
    case (phase_q)
      PH_LOAD: lim = CNT_W'(LOAD_LEN - 1);
      PH_MIX:  lim = CNT_W'(MIX_LEN - 1);
      default: lim = CNT_W'(RUN_LEN - 1);
    endcase
  end

  assign at_lim = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_LOAD;
          cnt_q   <= '0;
          sh_q    <= {frame_i, key_i};
          done_q  <= 1'b0;
        end
        PH_LOAD: begin
          sh_q <= sh_q >> 1;
          if (at_lim) begin
            phase_q <= PH_MIX;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_MIX: begin
          if (at_lim) begin
            phase_q <= PH_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_RUN: begin
          if (at_lim) begin
            phase_q <= PH_FIN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_FIN: begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o    = phase_q;
  assign clear_o    = (phase_q == PH_IDLE) && start_i;
  assign load_bit_o = (phase_q == PH_LOAD) && sh_q[0];
  assign done_o     = done_q;

endmodule

// File: rtl/kstream_gen.sv
module kstream_gen
  import kstream_pkg::*;
#(
  parameter int KEY_W   = 64,
  parameter int FRAME_W = 22,
  parameter int MIX_LEN = 100,
  parameter int RUN_LEN = 228
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               ks_o,
  output logic               ks_valid_o,
  output logic               done_o
);

  phase_e              phase;
  logic                clear;
  logic                load_bit;
  logic [N_REGS-1:0]   ctl;
  logic [N_REGS-1:0]   step_en;
  logic [N_REGS-1:0]   msb_nxt;
  logic [R1_LEN-1:0]   r1_state;
  logic [R2_LEN-1:0]   r2_state;
  logic [R3_LEN-1:0]   r3_state;
  logic                vote;
  logic                ks_q;
  logic                valid_q;

  kstream_seq #(
    .KEY_W  (KEY_W),
    .FRAME_W(FRAME_W),
    .MIX_LEN(MIX_LEN),
    .RUN_LEN(RUN_LEN)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .key_i     (key_i),
    .frame_i   (frame_i),
    .phase_o   (phase),
    .clear_o   (clear),
    .load_bit_o(load_bit),
    .done_o    (done_o)
  );

  assign vote = (phase == PH_MIX) || (phase == PH_RUN);

  kstream_clk_ctl #(.N(N_REGS)) u_ctl (
    .load_i(phase == PH_LOAD),
    .vote_i(vote),
    .ctl_i (ctl),
    .step_o(step_en)
  );

  kstream_lfsr #(.LEN(R1_LEN), .TAPS(R1_TAPS), .CTL_BIT(R1_CTL)) u_r1 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .step_i   (step_en[0]),
    .in_bit_i (load_bit),
    .state_o  (r1_state),
    .ctl_o    (ctl[0]),
    .msb_nxt_o(msb_nxt[0])
  );

  kstream_lfsr #(.LEN(R2_LEN), .TAPS(R2_TAPS), .CTL_BIT(R2_CTL)) u_r2 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .step_i   (step_en[1]),
    .in_bit_i (load_bit),
    .state_o  (r2_state),
    .ctl_o    (ctl[1]),
    .msb_nxt_o(msb_nxt[1])
  );

  kstream_lfsr #(.LEN(R3_LEN), .TAPS(R3_TAPS), .CTL_BIT(R3_CTL)) u_r3 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .step_i   (step_en[2]),
    .in_bit_i (load_bit),
    .state_o  (r3_state),
    .ctl_o    (ctl[2]),
    .msb_nxt_o(msb_nxt[2])
  );

  // output registered from post-step MSBs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ks_q    <= 1'b0;
    end else begin
      valid_q <= (phase == PH_RUN);
      ks_q    <= (phase == PH_RUN) && (^msb_nxt);
    end
  end

  assign ks_o       = ks_q;
  assign ks_valid_o = valid_q;

endmodule

// File: rtl/kstream_gen_chk.sv
module kstream_gen_chk
  import kstream_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input phase_e            phase_i,
  input logic [2:0]        step_i,
  input logic [R1_LEN-1:0] r1_i,
  input logic [R2_LEN-1:0] r2_i,
  input logic [R3_LEN-1:0] r3_i,
  input logic              ks_valid_i,
  input logic              done_i
);

  logic voting;
  assign voting = (phase_i == PH_MIX) || (phase_i == PH_RUN);

  assert_load_all_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_LOAD) |-> (step_i == 3'b111));

  assert_two_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    voting |-> ($countones(step_i) >= 2));

  assert_r1_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (voting && !step_i[0]) |=> $stable(r1_i));

  assert_r2_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (voting && !step_i[1]) |=> $stable(r2_i));

  assert_r3_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (voting && !step_i[2]) |=> $stable(r3_i));

  assert_mix_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_MIX) |-> !ks_valid_i);

  assert_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ks_valid_i && done_i));

  assert_done_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $past(ks_valid_i));

  assert_busy_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (voting || phase_i == PH_FIN)) |=> (phase_i != PH_LOAD));

endmodule

bind kstream_gen kstream_gen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .phase_i   (phase),
  .step_i    (step_en),
  .r1_i      (r1_state),
  .r2_i      (r2_state),
  .r3_i      (r3_state),
  .ks_valid_i(ks_valid_o),
  .done_i    (done_o)
);

// File: tb/tb_kstream_gen.sv
module tb_kstream_gen;

  localparam int RUN = 228;
  localparam int NV  = 4;
  localparam logic [85:0] VEC [NV] = '{
    {22'h000000, 64'h0000000000000000},
    {22'h000134, 64'h1223456789ABCDEF},
    {22'h3FFFFF, 64'hFFFFFFFFFFFFFFFF},
    {22'h2A5A5,  64'h0F1E2D3C4B5A6978}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] key_i = '0;
  logic [21:0] frame_i = '0;
  logic        ks_o, ks_valid_o, done_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  kstream_gen dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .key_i     (key_i),
    .frame_i   (frame_i),
    .ks_o      (ks_o),
    .ks_valid_o(ks_valid_o),
    .done_o    (done_o)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [227:0] act, input logic [227:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [RUN-1:0] ref_stream(input logic [63:0] k, input logic [21:0] f);
    logic [18:0] a;
    logic [21:0] b;
    logic [22:0] c;
    logic [85:0] s;
    logic [RUN-1:0] o;
    logic m, na, nb, nc;
    a = '0; b = '0; c = '0; o = '0;
    s = {f, k};
    for (int i = 0; i < 86; i++) begin
      na = a[13] ^ a[16] ^ a[17] ^ a[18] ^ s[i];
      nb = b[20] ^ b[21] ^ s[i];
      nc = c[7] ^ c[20] ^ c[21] ^ c[22] ^ s[i];
      a = {a[17:0], na};
      b = {b[20:0], nb};
      c = {c[21:0], nc};
    end
    for (int i = 0; i < 100 + RUN; i++) begin
      m  = (a[8] & b[10]) | (a[8] & c[10]) | (b[10] & c[10]);
      na = a[13] ^ a[16] ^ a[17] ^ a[18];
      nb = b[20] ^ b[21];
      nc = c[7] ^ c[20] ^ c[21] ^ c[22];
      if (a[8] == m)  a = {a[17:0], na};
      if (b[10] == m) b = {b[20:0], nb};
      if (c[10] == m) c = {c[21:0], nc};
      if (i >= 100) o[i-100] = a[18] ^ b[21] ^ c[22];
    end
    return o;
  endfunction

  // inj_idx: cycle for a stray start pulse (-1 none); chg_idx: cycle to alter key/frame
  task automatic burst(input logic [63:0] k, input logic [21:0] f,
                       input int inj_a, input int inj_b, input int chg_idx,
                       input string tag);
    logic [RUN-1:0] got, exp;
    int nbits, first_v, last_v, done_at;
    got = '0; nbits = 0; first_v = -1; last_v = -1; done_at = -1;
    exp = ref_stream(k, f);
    @(negedge clk_i);
    key_i = k; frame_i = f; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o == 1'b0, "R7", {tag, " done cleared by start"}, 228'(done_o), 228'(0));
    for (int idx = 0; idx < 600; idx++) begin
      if (ks_valid_o) begin
        if (first_v < 0) first_v = idx;
        last_v = idx;
        if (nbits < RUN) got[nbits] = ks_o;
        nbits++;
      end
      if (done_o) begin
        done_at = idx;
        break;
      end
      start_i = (idx == inj_a) || (idx == inj_b);
      if (idx == chg_idx) begin
        key_i = ~k; frame_i = ~f;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(first_v == 187, "R4", {tag, " first valid cycle"}, 228'(first_v), 228'(187));
    chk(nbits == RUN, "R6", {tag, " valid bit count"}, 228'(nbits), 228'(RUN));
    chk(got == exp, "R6", {tag, " keystream (R2 R3 R5)"}, got, exp);
    chk(done_at == last_v + 1 && last_v == 414, "R7", {tag, " done timing"},
        228'(done_at), 228'(415));
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk({ks_valid_o, ks_o, done_o} == 3'b000, "R1", "outputs in reset",
        228'({ks_valid_o, ks_o, done_o}), 228'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({ks_valid_o, ks_o, done_o} == 3'b000, "R1", "outputs after reset",
        228'({ks_valid_o, ks_o, done_o}), 228'(0));

    for (int v = 0; v < NV; v++) begin
      burst(VEC[v][63:0], VEC[v][85:64], -1, -1, -1, $sformatf("vec%0d", v));
      if (VEC[v] == '0)
        chk(ref_stream('0, '0) == '0, "R10", "zero model stream", 228'(0), 228'(0));
    end

    // R10: zero key gives zero output at the port
    begin
      int ones = 0;
      @(negedge clk_i); key_i = '0; frame_i = '0; start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
      for (int i = 0; i < 450 && !done_o; i++) begin
        if (ks_valid_o && ks_o) ones++;
        @(negedge clk_i);
      end
      chk(ones == 0, "R10", "zero key ones count", 228'(ones), 228'(0));
    end

    // R7: done holds while idle
    repeat (5) @(negedge clk_i);
    chk(done_o && !ks_valid_o, "R7", "done held while idle",
        228'({done_o, ks_valid_o}), 228'(2'b10));

    // R8: stray start pulses during load and keystream
    burst(64'hDEADBEEFCAFEF00D, 22'h155555, 10, 250, -1, "R8 stray start");
    // R8: stray start during mixing
    burst(64'h0123456789ABCDEF, 22'h0ABCDE, 120, -1, -1, "R8 start in mix");
    // R9: key/frame altered right after acceptance
    burst(64'h8000000000000001, 22'h200001, -1, -1, 0, "R9 input change");
    // R9: key/frame altered mid-load
    burst(64'h5555AAAA3333CCCC, 22'h0F0F0F, -1, -1, 40, "R9 change in load");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule